// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

The block holds two 8-bit up-counters. Each has its own compare value, enable and match interrupt. When run separately, each counter counts ticks from its own prescaled clock. On the tick where its count equals its compare value it clears to zero and pulses its interrupt. This gives a periodic interrupt every compare+1 ticks. A shared free-running prescaler offers divide-by 1, 2, 4 and 8.

A mode bit in the upper timer's control register chains the two counters into one 16-bit interval timer. In that mode only the lower timer's clock select applies. The lower counter carries into the upper one. When the combined count matches the combined compare value, the lower interrupt fires and both counters clear. The upper interrupt still fires whenever a carry brings the upper count to its own compare value. Software sets up the block through a small write port. Compare values accept writes only while both timers are stopped. To start, the upper timer is enabled first and the lower timer after it.

Top module: `cascade_interval_timer`

## Requirements
- R1: After reset both counters read 0, both interrupts are low, both enables and the chain mode are 0, and both compare values are 00H.
- R2: In separate mode, an enabled counter advances by one on each of its ticks. On a tick where its count equals its compare value it goes to 0 instead, and its interrupt is high for the following cycle only. The interrupt therefore repeats every compare+1 ticks, for any compare value from 00H to FFH.
- R3: A 2-bit clock select of 0, 1, 2 or 3 gives a tick every 1, 2, 4 or 8 system clock cycles.
- R4: In separate mode, clearing a timer's enable holds that counter at its current value.
- R5: In chain mode the lower counter holds bits 7:0 and the upper counter bits 15:8 of one 16-bit count. The upper counter advances on each tick where the lower counter wraps from FFH to 00H without a match.
- R6: In chain mode, a tick where the 16-bit count equals {upper compare, lower compare} clears both counters and pulses the lower interrupt. The period is the 16-bit compare value plus one tick.
- R7: In chain mode the upper timer's clock select has no effect. Counting follows the lower select only.
- R8: In chain mode the upper interrupt pulses for one cycle when a carry brings the upper counter to the upper compare value.
- R9: In chain mode, with the upper enable set, the lower enable alone stops (holding both counters) or restarts the 16-bit count. With the upper enable clear, both counters are forced to 0 and do not count.
- R10: A compare-value write that arrives while either enable is 1 is ignored.
- R11: Write map: address 0 is the lower compare value and address 1 the upper compare value. Address 2 is lower control (bit 0 enable, bits 2:1 clock select). Address 3 is upper control (bit 0 enable, bits 2:1 clock select, bit 4 chain mode). Writes to addresses 4 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| cnt_lo | output | 8 | Lower counter value |
| cnt_hi | output | 8 | Upper counter value |
| irq_lo | output | 1 | Lower match interrupt pulse |
| irq_hi | output | 1 | Upper match interrupt pulse |

## Verification
The bench drives compare values of 00H and FFH. A design that matched one tick late or early would give the wrong interrupt count and final value, and with 00H it would stop firing on every tick. In the chained run it checks the carry point and the 16-bit match point. An off-by-one carry, or an upper timer counting on its own clock, would shift the count at those cycles. It then writes a compare value to a running timer, stops and restarts the chain with the lower enable alone, and clears the upper enable. A design that honoured the write would lengthen the period. One that ignored the lower enable would drift, and one that kept counting after the upper enable clears would fail to read zero.

// File: rtl/cit_pkg.sv
package cit_pkg;
    localparam int CNT_W    = 8;
    localparam int SEL_W    = 2;
    localparam int ADDR_W   = 3;

    // write-map addresses
    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTL_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTL_HI = 3'd3;

    // control field positions
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_SEL_LSB  = 1;
    localparam int CTL_CHAIN_BIT = 4;
endpackage

// File: rtl/cit_prescale.sv
module cit_prescale #(
    parameter int SEL_W = cit_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    output logic             tick_a,
    output logic             tick_b
);
    localparam int NTAP = 1 << SEL_W;
    localparam int PW   = (NTAP > 1) ? NTAP - 1 : 1;

    logic [PW-1:0]   pre_d, pre_q;
    logic [NTAP-1:0] tap;

    always_comb begin
        pre_d = PW'(pre_q + 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // tap i fires once every 2**i cycles
    for (genvar gi = 0; gi < NTAP; gi++) begin : g_tap
        if (gi == 0) begin : g_div1
            assign tap[gi] = 1'b1;
        end else begin : g_divn
            assign tap[gi] = &pre_q[gi-1:0];
        end
    end

    assign tick_a = tap[sel_a];
    assign tick_b = tap[sel_b];
endmodule

// File: rtl/cit_regs.sv
module cit_regs #(
    parameter int CW     = cit_pkg::CNT_W,
    parameter int SEL_W  = cit_pkg::SEL_W,
    parameter int ADDR_W = cit_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output logic [CW-1:0]     cmp_lo,
    output logic [CW-1:0]     cmp_hi,
    output logic              en_lo,
    output logic              en_hi,
    output logic              chain,
    output logic [SEL_W-1:0]  sel_lo,
    output logic [SEL_W-1:0]  sel_hi
);
    import cit_pkg::*;

    typedef struct packed {
        logic [CW-1:0]    cmp_lo;
        logic [CW-1:0]    cmp_hi;
        logic             en_lo;
        logic             en_hi;
        logic             chain;
        logic [SEL_W-1:0] sel_lo;
        logic [SEL_W-1:0] sel_hi;
    } regs_t;

    regs_t r_d, r_q;
    logic  locked;

    always_comb begin
        r_d    = r_q;
        locked = r_q.en_lo | r_q.en_hi;
        if (wr_en) begin
            case (wr_addr)
                A_CMP_LO: if (!locked) r_d.cmp_lo = wr_data;
                A_CMP_HI: if (!locked) r_d.cmp_hi = wr_data;
                A_CTL_LO: begin
                    r_d.en_lo  = wr_data[CTL_EN_BIT];
                    r_d.sel_lo = wr_data[CTL_SEL_LSB +: SEL_W];
                end
                A_CTL_HI: begin
                    r_d.en_hi  = wr_data[CTL_EN_BIT];
                    r_d.sel_hi = wr_data[CTL_SEL_LSB +: SEL_W];
                    r_d.chain  = wr_data[CTL_CHAIN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmp_lo = r_q.cmp_lo;
    assign cmp_hi = r_q.cmp_hi;
    assign en_lo  = r_q.en_lo;
    assign en_hi  = r_q.en_hi;
    assign chain  = r_q.chain;
    assign sel_lo = r_q.sel_lo;
    assign sel_hi = r_q.sel_hi;
endmodule

// File: rtl/cit_core.sv
module cit_core #(
    parameter int CW = cit_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_lo,
    input  logic          en_hi,
    input  logic          chain,
    input  logic          tick_lo,
    input  logic          tick_hi,
    input  logic [CW-1:0] cmp_lo,
    input  logic [CW-1:0] cmp_hi,
    output logic [CW-1:0] cnt_lo,
    output logic [CW-1:0] cnt_hi,
    output logic          irq_lo,
    output logic          irq_hi
);
    typedef struct packed {
        logic [CW-1:0] cnt_lo;
        logic [CW-1:0] cnt_hi;
        logic          irq_lo;
        logic          irq_hi;
    } core_t;

    core_t         c_d, c_q;
    logic [CW-1:0] lo_inc, hi_inc;
    logic          lo_match, hi_match, lo_wrap;

    always_comb begin
        lo_inc   = CW'(c_q.cnt_lo + 1'b1);
        hi_inc   = CW'(c_q.cnt_hi + 1'b1);
        lo_match = (c_q.cnt_lo == cmp_lo);
        hi_match = (c_q.cnt_hi == cmp_hi);
        lo_wrap  = &c_q.cnt_lo;

        c_d        = c_q;
        c_d.irq_lo = 1'b0;
        c_d.irq_hi = 1'b0;

        if (chain) begin
            if (!en_hi) begin
                // upper enable off: chained count is parked at zero
                c_d.cnt_lo = '0;
                c_d.cnt_hi = '0;
            end else if (en_lo && tick_lo) begin
                if (lo_match && hi_match) begin
                    c_d.cnt_lo = '0;
                    c_d.cnt_hi = '0;
                    c_d.irq_lo = 1'b1;
                end else begin
                    c_d.cnt_lo = lo_inc;
                    if (lo_wrap) begin
                        c_d.cnt_hi = hi_inc;
                        c_d.irq_hi = (hi_inc == cmp_hi);
                    end
                end
            end
        end else begin
            if (en_lo && tick_lo) begin
                if (lo_match) begin
                    c_d.cnt_lo = '0;
                    c_d.irq_lo = 1'b1;
                end else begin
                    c_d.cnt_lo = lo_inc;
                end
            end
            if (en_hi && tick_hi) begin
                if (hi_match) begin
                    c_d.cnt_hi = '0;
                    c_d.irq_hi = 1'b1;
                end else begin
                    c_d.cnt_hi = hi_inc;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_lo = c_q.cnt_lo;
    assign cnt_hi = c_q.cnt_hi;
    assign irq_lo = c_q.irq_lo;
    assign irq_hi = c_q.irq_hi;
endmodule

// File: rtl/cascade_interval_timer.sv
module cascade_interval_timer #(
    parameter int CW     = cit_pkg::CNT_W,
    parameter int SEL_W  = cit_pkg::SEL_W,
    parameter int ADDR_W = cit_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output logic [CW-1:0]     cnt_lo,
    output logic [CW-1:0]     cnt_hi,
    output logic              irq_lo,
    output logic              irq_hi
);
    logic [CW-1:0]    cmp_lo_w, cmp_hi_w;
    logic             en_lo_w, en_hi_w, chain_w;
    logic [SEL_W-1:0] sel_lo_w, sel_hi_w;
    logic             tick_lo_w, tick_hi_w;

    cit_regs #(.CW(CW), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmp_lo  (cmp_lo_w),
        .cmp_hi  (cmp_hi_w),
        .en_lo   (en_lo_w),
        .en_hi   (en_hi_w),
        .chain   (chain_w),
        .sel_lo  (sel_lo_w),
        .sel_hi  (sel_hi_w)
    );

    cit_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_a  (sel_lo_w),
        .sel_b  (sel_hi_w),
        .tick_a (tick_lo_w),
        .tick_b (tick_hi_w)
    );

    cit_core #(.CW(CW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_lo   (en_lo_w),
        .en_hi   (en_hi_w),
        .chain   (chain_w),
        .tick_lo (tick_lo_w),
        .tick_hi (tick_hi_w),
        .cmp_lo  (cmp_lo_w),
        .cmp_hi  (cmp_hi_w),
        .cnt_lo  (cnt_lo),
        .cnt_hi  (cnt_hi),
        .irq_lo  (irq_lo),
        .irq_hi  (irq_hi)
    );
endmodule

// File: rtl/cit_checker.sv
module cit_checker #(
    parameter int CW = cit_pkg::CNT_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_lo,
    input logic          en_hi,
    input logic          chain,
    input logic [CW-1:0] cmp_lo,
    input logic [CW-1:0] cmp_hi,
    input logic [CW-1:0] cnt_lo,
    input logic [CW-1:0] cnt_hi,
    input logic          irq_lo,
    input logic          irq_hi
);
    // R2: a separate-mode lower interrupt coincides with a cleared counter
    a_r2_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo && !chain && !$past(chain)) |-> (cnt_lo == '0));

    // R4: a stopped separate-mode lower counter holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain && !en_lo) |=> $stable(cnt_lo));

    // R5: the lower counter only steps by one or returns to zero
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_lo) |-> ((cnt_lo == CW'($past(cnt_lo) + 1'b1)) || (cnt_lo == '0)));

    // R6: a chained match leaves both counters at zero
    a_r6_irq_clears_both: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo && chain && $past(chain)) |-> (cnt_lo == '0 && cnt_hi == '0));

    // R8: a chained upper interrupt arrives with the upper count at its compare value
    a_r8_hi_at_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi && chain && $past(chain)) |-> (cnt_hi == cmp_hi));

    // R9: upper enable off in chain mode forces zero
    a_r9_upper_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (chain && !en_hi) |=> (cnt_lo == '0 && cnt_hi == '0));

    // R9: lower enable off in chain mode holds both counters
    a_r9_lower_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (chain && en_hi && !en_lo) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

    // R10: compare values are frozen while any timer runs
    a_r10_cmp_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lo || en_hi) |=> ($stable(cmp_lo) && $stable(cmp_hi)));
endmodule

bind cascade_interval_timer cit_checker #(.CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_lo  (en_lo_w),
    .en_hi  (en_hi_w),
    .chain  (chain_w),
    .cmp_lo (cmp_lo_w),
    .cmp_hi (cmp_hi_w),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi),
    .irq_lo (irq_lo),
    .irq_hi (irq_hi)
);

// File: tb/tb_cascade_interval_timer.sv
`timescale 1ns/1ps
module tb_cascade_interval_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] cnt_lo, cnt_hi;
    logic       irq_lo, irq_hi;

    int checks = 0;
    int errs   = 0;

    always #2 clk = ~clk;   // 250 MHz

    cascade_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // vector table: timer (0 lower, 1 upper), compare, edges run, expected count, expected interrupts
    localparam int NV = 7;
    localparam int V_SIDE [NV] = '{0, 0, 0, 0, 0, 0, 1};
    localparam int V_CMP  [NV] = '{0, 3, 7, 255, 1, 200, 5};
    localparam int V_RUN  [NV] = '{5, 10, 8, 300, 7, 200, 13};
    localparam int V_CNT  [NV] = '{0, 2, 0, 44, 1, 200, 1};
    localparam int V_IRQ  [NV] = '{5, 2, 1, 1, 3, 0, 2};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        chk("watchdog", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int irqs;
        int v0;
        int gap;
        int maxc;
        int ih;

        // R1: reset state
        do_reset();
        chk("R1 cnt_lo", cnt_lo, 0);
        chk("R1 cnt_hi", cnt_hi, 0);
        chk("R1 irq_lo", irq_lo, 0);
        chk("R1 irq_hi", irq_hi, 0);

        // R2: table walk, separate mode, divide-by-1
        for (int v = 0; v < NV; v++) begin
            do_reset();
            wr(V_SIDE[v] ? 3'd1 : 3'd0, 8'(V_CMP[v]));
            wr(V_SIDE[v] ? 3'd3 : 3'd2, 8'h01);
            irqs = 0;
            for (int k = 0; k < V_RUN[v]; k++) begin
                @(negedge clk);
                irqs += V_SIDE[v] ? int'(irq_hi) : int'(irq_lo);
            end
            chk("R2 count", V_SIDE[v] ? int'(cnt_hi) : int'(cnt_lo), V_CNT[v]);
            chk("R2 interrupts", irqs, V_IRQ[v]);
        end

        // R3: prescaler spacing between increments
        for (int s = 0; s < 4; s++) begin
            do_reset();
            wr(3'd0, 8'hFF);
            wr(3'd2, 8'((s << 1) | 1));
            v0 = cnt_lo;
            for (int k = 0; k < 20 && cnt_lo == 8'(v0); k++) @(negedge clk);
            v0 = cnt_lo;
            gap = 0;
            for (int k = 0; k < 20 && cnt_lo == 8'(v0); k++) begin
                @(negedge clk);
                gap++;
            end
            chk("R3 divide", gap, 1 << s);
        end

        // R4: stop holds the count
        do_reset();
        wr(3'd0, 8'hFF);
        wr(3'd2, 8'h01);
        repeat (6) @(negedge clk);
        wr(3'd2, 8'h00);
        v0 = cnt_lo;
        repeat (10) @(negedge clk);
        chk("R4 hold", cnt_lo, v0);

        // R10: compare write to a running timer is ignored
        do_reset();
        wr(3'd0, 8'd3);
        wr(3'd2, 8'h01);
        wr(3'd0, 8'd10);
        irqs = 0;
        maxc = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            irqs += int'(irq_lo);
            if (int'(cnt_lo) > maxc) maxc = cnt_lo;
        end
        chk("R10 period kept", irqs, 10);
        chk("R10 max count", maxc, 3);

        // R11: unmapped addresses have no effect
        do_reset();
        for (int a = 4; a < 8; a++) wr(3'(a), 8'hFF);
        repeat (10) @(negedge clk);
        chk("R11 no start lo", cnt_lo, 0);
        chk("R11 no start hi", cnt_hi, 0);

        // R5..R8: chained run, compare 0205H, upper select set to divide-by-8
        do_reset();
        wr(3'd0, 8'h05);
        wr(3'd1, 8'h02);
        wr(3'd3, 8'h17);
        repeat (4) @(negedge clk);
        chk("R9 upper only stays zero", {24'd0, cnt_hi, cnt_lo}, 0);
        wr(3'd2, 8'h01);
        irqs = 0;
        ih = 0;
        for (int k = 1; k <= 1036; k++) begin
            @(negedge clk);
            irqs += int'(irq_lo);
            ih   += int'(irq_hi);
            if (k == 260) begin
                chk("R5 R7 hi at 260", cnt_hi, 1);
                chk("R5 R7 lo at 260", cnt_lo, 4);
            end
            if (k == 512) begin
                chk("R8 irq_hi at carry", irq_hi, 1);
                chk("R5 hi at 512", cnt_hi, 2);
            end
            if (k == 518) begin
                chk("R6 irq_lo at match", irq_lo, 1);
                chk("R6 cleared", {24'd0, cnt_hi, cnt_lo}, 0);
            end
        end
        chk("R6 interrupt count", irqs, 2);
        chk("R8 upper interrupt count", ih, 2);

        // R9: lower enable stops/restarts, upper enable clears
        repeat (100) @(negedge clk);
        chk("R9 running", {24'd0, cnt_hi, cnt_lo}, 100);
        wr(3'd2, 8'h00);
        v0 = {cnt_hi, cnt_lo};
        repeat (10) @(negedge clk);
        chk("R9 lower stop holds", {24'd0, cnt_hi, cnt_lo}, v0);
        wr(3'd2, 8'h01);
        repeat (5) @(negedge clk);
        chk("R9 lower restart", {24'd0, cnt_hi, cnt_lo}, v0 + 5);
        wr(3'd3, 8'h10);
        @(negedge clk);
        chk("R9 upper off zero", {24'd0, cnt_hi, cnt_lo}, 0);
        repeat (3) @(negedge clk);
        chk("R9 upper off stays zero", {24'd0, cnt_hi, cnt_lo}, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule